// File: doc/BRIEF.md
# Per-Slot Source Time-Slot Switch

This block switches bytes between time-division highways. Bytes arriving on any of several receive highways are written into a data memory, addressed by highway and receive slot. A single transmit highway of `TX_SLOTS` slots is produced as a serial bit stream with an output-enable. For each transmit slot, a 16-bit connection entry chooses one of eight sources. Two sources switch a received byte: one gives the lowest delay and one keeps whole frames intact. The other six are a literal byte held in the entry itself, one of three shared idle bytes, an external test-pattern byte, or a released (undriven) line.

The data memory has two banks, one per frame. A frame-sync pulse swaps the banks and restarts the transmit slot sequence. Frame-integrity slots read the bank that was completed before the most recent sync, so every byte they send comes from the same finished receive frame. Low-latency slots read the bank that is being filled. A host port loads connection entries and the three idle registers. Releasing the line in chosen slots lets several devices share one highway, each device driving only its own slots.

Top module: `tsi_slot_switch`

## Requirements
- R1: Reset sets every connection entry to the high-impedance mode and sets all three idle registers to 0xFF. `txOe` stays low from reset until the first `frameSync`.
- R2: When `frameSync` is sampled high at a clock edge, the transmit sequence restarts at slot 0. Bit 7 of the slot-0 byte is on `txBit` in the cycle after that edge. Each slot lasts 8 cycles and is sent most-significant bit first. Slots follow in ascending order and wrap from `TX_SLOTS-1` to 0.
- R3: Entry bits 15:13 hold the mode, and bits 12:8 hold the receive highway, of which only the low log2(`NUM_HWY`) bits are used. Bits 6:0 hold the receive slot. The mode codes are: 0 low-latency, 1 frame-integrity, 2 host byte, 3/4/5 idle register 0/1/2, 6 test pattern, 7 high impedance.
- R4: A low-latency slot sends the byte most recently written, in the current receive frame, to the addressed highway and slot.
- R5: A frame-integrity slot sends the byte that the addressed highway and slot held at the end of the receive frame completed by the last `frameSync`. Receive writes made after that sync do not change it.
- R6: A host-byte slot sends entry bits 7:0.
- R7: An idle-mode slot sends the selected idle register. A host write with `hostIdleSel` high and `hostAddr[1:0]` equal to 0, 1 or 2 loads that register from `hostWrData[7:0]`. The value 3 is ignored.
- R8: A test-pattern slot sends the value of `patByte` that was present at the clock edge where the slot's byte is fetched (the last bit edge of the previous slot, or the sync edge for slot 0).
- R9: A high-impedance slot holds `txOe` low, with `txBit` low, for all 8 bits. `txOe` changes only at slot boundaries.
- R10: A connection-entry write takes effect from the next fetch of that slot. A write made while the slot is being sent leaves the rest of that slot unchanged.
- R11: Entry bit 7 is ignored in the two switching modes. Entry bits 12:0 are ignored in the idle and test-pattern modes, and bits 12:8 are ignored in host-byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one transmit bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frameSync | input | 1 | Frame start pulse: swaps banks, restarts at slot 0 |
| rxValid | input | 1 | Receive byte strobe |
| rxHwy | input | log2(NUM_HWY) | Receive highway of the byte |
| rxSlot | input | log2(RX_SLOTS) | Receive slot of the byte |
| rxData | input | 8 | Received byte |
| hostWrEn | input | 1 | Host write strobe |
| hostIdleSel | input | 1 | 1: write idle register, 0: write connection entry |
| hostAddr | input | log2(TX_SLOTS) | Transmit slot, or idle register index in bits 1:0 |
| hostWrData | input | 16 | Entry value; bits 7:0 for idle registers |
| patByte | input | 8 | External test-pattern byte |
| txBit | output | 1 | Serial transmit data, MSB first |
| txOe | output | 1 | Transmit drive enable |

## Verification
The bench places both switching modes on the same receive addresses, and each frame writes new receive bytes during slot 0. A design that read the wrong bank for either mode would therefore send the other mode's value, or a byte from two frames back. A host entry is rewritten in the middle of its own slot: a design that took the entry bits at the wrong time would corrupt that slot's remaining bits, instead of changing the slot only in the next frame. The entries also carry junk in their ignored fields, including highway numbers above `NUM_HWY` and a set bit 7 in the slot address. A write to idle index 3 and idle slots that are read before any idle write test the ignore rules and the reset value of the idle registers.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef enum logic [2:0] {
    MODE_LIVE    = 3'd0,
    MODE_FRAME   = 3'd1,
    MODE_HOST    = 3'd2,
    MODE_IDLE0   = 3'd3,
    MODE_IDLE1   = 3'd4,
    MODE_IDLE2   = 3'd5,
    MODE_PATTERN = 3'd6,
    MODE_HIZ     = 3'd7
  } srcMode_e;

  // strobes from the slot sequencer to the datapath
  typedef struct packed {
    logic load;      // fetch the next slot's byte into the shifter
    logic shift;     // advance the shifter by one bit
    logic liveBank;  // bank seen by low-latency reads at this edge
    logic wrBank;    // bank receiving bytes at this edge
  } txCtl_t;

  localparam logic [15:0] ENTRY_RESET = 16'hE000;
  localparam int IDLE_CODES = 3;

endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int TX_SLOTS = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frameSync,
  output txCtl_t                      ctl,
  output logic [$clog2(TX_SLOTS)-1:0] fetchSlot
);

  localparam int SLOT_W = $clog2(TX_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(TX_SLOTS - 1);

  logic              running;
  logic [2:0]        bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              wrBank;
  logic              slotEnd;

  assign slotEnd = running && (bitCnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      bitCnt  <= '0;
      slotCnt <= '0;
      wrBank  <= 1'b0;
    end else if (frameSync) begin
      running <= 1'b1;
      bitCnt  <= '0;
      slotCnt <= '0;
      wrBank  <= ~wrBank;
    end else if (running) begin
      bitCnt <= bitCnt + 3'd1;
      if (slotEnd) slotCnt <= (slotCnt == LAST_SLOT) ? '0 : slotCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.load     = frameSync | slotEnd;
    ctl.shift    = running & ~ctl.load;
    ctl.liveBank = frameSync ? ~wrBank : wrBank;
    ctl.wrBank   = wrBank;
    if (frameSync || slotCnt == LAST_SLOT) fetchSlot = '0;
    else                                   fetchSlot = slotCnt + 1'b1;
  end

endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int NUM_HWY  = 4,
  parameter int RX_SLOTS = 128,
  parameter int TX_SLOTS = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  txCtl_t                      ctl,
  input  logic [$clog2(TX_SLOTS)-1:0] fetchSlot,
  input  logic                        rxValid,
  input  logic [$clog2(NUM_HWY)-1:0]  rxHwy,
  input  logic [$clog2(RX_SLOTS)-1:0] rxSlot,
  input  logic [7:0]                  rxData,
  input  logic                        hostWrEn,
  input  logic                        hostIdleSel,
  input  logic [$clog2(TX_SLOTS)-1:0] hostAddr,
  input  logic [15:0]                 hostWrData,
  input  logic [7:0]                  patByte,
  output logic                        txBit,
  output logic                        txOe
);

  localparam int HWY_W   = $clog2(NUM_HWY);
  localparam int RSLOT_W = $clog2(RX_SLOTS);
  localparam int DM_W    = 1 + HWY_W + RSLOT_W;
  localparam int DM_SIZE = 2 * NUM_HWY * RX_SLOTS;

  logic [15:0] connMem [TX_SLOTS];
  logic [7:0]  dataMem [DM_SIZE];
  logic [7:0]  idleReg [IDLE_CODES];

  // connection memory: host writes, reset to released line
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TX_SLOTS; i++) connMem[i] <= ENTRY_RESET;
    end else if (hostWrEn && !hostIdleSel) begin
      connMem[hostAddr] <= hostWrData;
    end
  end

  // idle code registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < IDLE_CODES; i++) idleReg[i] <= 8'hFF;
    end else if (hostWrEn && hostIdleSel) begin
      for (int i = 0; i < IDLE_CODES; i++)
        if (hostAddr[1:0] == 2'(i)) idleReg[i] <= hostWrData[7:0];
    end
  end

  // frame-banked receive store
  always_ff @(posedge clk) begin
    if (rxValid) dataMem[{ctl.wrBank, rxHwy, rxSlot}] <= rxData;
  end

  // source selection for the slot being fetched
  logic [15:0]        entry;
  srcMode_e           mode;
  logic [HWY_W-1:0]   selHwy;
  logic [RSLOT_W-1:0] selSlot;
  logic [DM_W-1:0]    liveIdx;
  logic [DM_W-1:0]    frozenIdx;
  logic [7:0]         nextByte;
  logic               nextOe;
  logic [4-HWY_W:0]   unusedHwyHigh;

  always_comb begin
    entry         = connMem[fetchSlot];
    mode          = srcMode_e'(entry[15:13]);
    selHwy        = entry[8 +: HWY_W];
    unusedHwyHigh = entry[12:8+HWY_W-1];
    selSlot       = entry[RSLOT_W-1:0];
    liveIdx       = {ctl.liveBank, selHwy, selSlot};
    frozenIdx     = {~ctl.liveBank, selHwy, selSlot};
    nextOe        = 1'b1;
    nextByte      = 8'h00;
    case (mode)
      MODE_LIVE:    nextByte = dataMem[liveIdx];
      MODE_FRAME:   nextByte = dataMem[frozenIdx];
      MODE_HOST:    nextByte = entry[7:0];
      MODE_IDLE0:   nextByte = idleReg[0];
      MODE_IDLE1:   nextByte = idleReg[1];
      MODE_IDLE2:   nextByte = idleReg[2];
      MODE_PATTERN: nextByte = patByte;
      MODE_HIZ:     nextOe   = 1'b0;
      default:      nextOe   = 1'b0;
    endcase
  end

  // parallel-to-serial, MSB first
  logic [7:0] shReg;
  logic       oeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg <= '0;
      oeReg <= 1'b0;
    end else if (ctl.load) begin
      shReg <= nextOe ? nextByte : 8'h00;
      oeReg <= nextOe;
    end else if (ctl.shift) begin
      shReg <= {shReg[6:0], 1'b0};
    end
  end

  assign txBit = oeReg & shReg[7];
  assign txOe  = oeReg;

endmodule

// File: rtl/tsi_slot_switch.sv
module tsi_slot_switch
  import tsi_pkg::*;
#(
  parameter int NUM_HWY  = 4,
  parameter int RX_SLOTS = 128,
  parameter int TX_SLOTS = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frameSync,
  input  logic                        rxValid,
  input  logic [$clog2(NUM_HWY)-1:0]  rxHwy,
  input  logic [$clog2(RX_SLOTS)-1:0] rxSlot,
  input  logic [7:0]                  rxData,
  input  logic                        hostWrEn,
  input  logic                        hostIdleSel,
  input  logic [$clog2(TX_SLOTS)-1:0] hostAddr,
  input  logic [15:0]                 hostWrData,
  input  logic [7:0]                  patByte,
  output logic                        txBit,
  output logic                        txOe
);

  txCtl_t                      ctl;
  logic [$clog2(TX_SLOTS)-1:0] fetchSlot;

  tsi_ctrl #(.TX_SLOTS(TX_SLOTS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .frameSync (frameSync),
    .ctl       (ctl),
    .fetchSlot (fetchSlot)
  );

  tsi_datapath #(
    .NUM_HWY  (NUM_HWY),
    .RX_SLOTS (RX_SLOTS),
    .TX_SLOTS (TX_SLOTS)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .fetchSlot   (fetchSlot),
    .rxValid     (rxValid),
    .rxHwy       (rxHwy),
    .rxSlot      (rxSlot),
    .rxData      (rxData),
    .hostWrEn    (hostWrEn),
    .hostIdleSel (hostIdleSel),
    .hostAddr    (hostAddr),
    .hostWrData  (hostWrData),
    .patByte     (patByte),
    .txBit       (txBit),
    .txOe        (txOe)
  );

endmodule

// File: rtl/tsi_slot_switch_chk.sv
module tsi_slot_switch_chk (
  input logic clk,
  input logic rst,
  input logic frameSync,
  input logic txBit,
  input logic txOe
);

  logic       started;
  logic [2:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      ph      <= '0;
    end else if (frameSync) begin
      started <= 1'b1;
      ph      <= '0;
    end else if (started) begin
      ph <= ph + 3'd1;
    end
  end

  // R1: line released in the first cycle out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !txOe);

  // R1: nothing driven before the first frame sync
  assert_quiet_before_sync_R1: assert property (@(posedge clk) disable iff (rst)
    !started |-> !txOe);

  // R9: enable only moves at slot boundaries
  assert_oe_slot_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (started && !frameSync && ph != 3'd7) |=> $stable(txOe));

  // R9: data line low whenever released
  assert_hiz_quiet_line_R9: assert property (@(posedge clk) disable iff (rst)
    !txOe |-> !txBit);

endmodule

bind tsi_slot_switch tsi_slot_switch_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .frameSync (frameSync),
  .txBit     (txBit),
  .txOe      (txOe)
);

// File: tb/test_tsi_slot_switch.sv
`timescale 1ns/1ps
module test_tsi_slot_switch;

  localparam int NUM_HWY  = 4;
  localparam int RX_SLOTS = 128;
  localparam int TX_SLOTS = 32;

  typedef struct {
    logic [7:0] data;
    logic       oe;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frameSync = 1'b0;
  logic        rxValid = 1'b0;
  logic [1:0]  rxHwy = '0;
  logic [6:0]  rxSlot = '0;
  logic [7:0]  rxData = '0;
  logic        hostWrEn = 1'b0;
  logic        hostIdleSel = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [7:0]  patByte = '0;
  logic        txBit;
  logic        txOe;

  always #2 clk = ~clk;

  tsi_slot_switch #(.NUM_HWY(NUM_HWY), .RX_SLOTS(RX_SLOTS), .TX_SLOTS(TX_SLOTS)) i_tsi_slot_switch (
    .clk(clk), .rst(rst), .frameSync(frameSync),
    .rxValid(rxValid), .rxHwy(rxHwy), .rxSlot(rxSlot), .rxData(rxData),
    .hostWrEn(hostWrEn), .hostIdleSel(hostIdleSel), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .patByte(patByte), .txBit(txBit), .txOe(txOe)
  );

  int checks = 0;
  int fails = 0;
  int framesDone = 0;
  bit finished = 0;
  exp_t expQ[$];
  event frameStart;

  // bench-side model
  logic [15:0] entryM [TX_SLOTS];
  string       tagM   [TX_SLOTS];
  logic [7:0]  idleM  [3];
  logic [7:0]  memM   [2][NUM_HWY][RX_SLOTS];
  bit          bankM = 0;
  int          rxH [6] = '{0, 1, 2, 3, 2, 0};
  int          rxA [6] = '{5, 127, 0, 64, 33, 100};

  function automatic exp_t expectFor(int s);
    exp_t e;
    logic [2:0] m = entryM[s][15:13];
    int h = int'(entryM[s][9:8]);
    int a = int'(entryM[s][6:0]);
    e.oe = 1'b1; e.data = 8'h00; e.tag = tagM[s];
    case (m)
      3'd0: e.data = memM[bankM][h][a];
      3'd1: e.data = memM[!bankM][h][a];
      3'd2: e.data = entryM[s][7:0];
      3'd3, 3'd4, 3'd5: e.data = idleM[m - 3'd3];
      3'd6: e.data = patByte;
      default: e.oe = 1'b0;
    endcase
    return e;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  task automatic setEntry(int s, logic [7:0] hi, logic [7:0] lo, string tag);
    @(negedge clk);
    hostWrEn = 1; hostIdleSel = 0; hostAddr = 5'(s); hostWrData = {hi, lo};
    @(negedge clk);
    hostWrEn = 0;
    entryM[s] = {hi, lo};
    tagM[s] = tag;
  endtask

  task automatic setIdle(int i, logic [7:0] v);
    @(negedge clk);
    hostWrEn = 1; hostIdleSel = 1; hostAddr = 5'(i); hostWrData = {8'h5A, v};
    @(negedge clk);
    hostWrEn = 0; hostIdleSel = 0;
    if (i < 3) idleM[i] = v;
  endtask

  task automatic rxOne(int h, int a, logic [7:0] d);
    @(negedge clk);
    rxValid = 1; rxHwy = 2'(h); rxSlot = 7'(a); rxData = d;
    memM[bankM][h][a] = d;
    @(negedge clk);
    rxValid = 0;
  endtask

  // driver: sync, in-frame receive writes during slot 0, expectations queued
  task automatic runFrame(logic [7:0] rxBase);
    @(negedge clk);
    frameSync = 1;
    bankM = !bankM;
    expQ.push_back(expectFor(0));
    ->frameStart;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      frameSync = 0;
      rxValid = 1; rxHwy = 2'(rxH[k]); rxSlot = 7'(rxA[k]); rxData = rxBase + 8'(k);
      memM[bankM][rxH[k]][rxA[k]] = rxBase + 8'(k);
    end
    @(negedge clk);
    rxValid = 0;
    for (int s = 1; s < TX_SLOTS; s++) expQ.push_back(expectFor(s));
  endtask

  // monitor: collects each slot and compares with the queue
  initial begin
    forever begin
      @(frameStart);
      for (int s = 0; s < TX_SLOTS; s++) begin
        logic [7:0] got;
        logic oeAll1, oeAny1;
        exp_t e;
        oeAll1 = 1; oeAny1 = 0;
        for (int b = 7; b >= 0; b--) begin
          @(negedge clk);
          got[b] = txBit;
          oeAll1 &= txOe;
          oeAny1 |= txOe;
        end
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL scoreboard empty at slot %0d (R2): actual %02h expected none", s, got);
        end else begin
          e = expQ.pop_front();
          if (e.oe ? !(oeAll1 && got == e.data) : (oeAny1 || got != 8'h00)) begin
            fails++;
            $display("FAIL %s slot %0d: actual oe=%0b/%0b byte %02h expected oe=%0b byte %02h",
                     e.tag, s, oeAny1, oeAll1, got, e.oe, e.data);
          end
        end
      end
      framesDone++;
    end
  end

  initial begin
    #(4 * 50000);
    fails++;
    $display("FAIL watchdog (R2): actual hang expected completion");
    finish();
  end

  initial begin
    for (int s = 0; s < TX_SLOTS; s++) begin entryM[s] = 16'hE000; tagM[s] = "R1 R9"; end
    for (int i = 0; i < 3; i++) idleM[i] = 8'hFF;
    for (int b = 0; b < 2; b++)
      for (int h = 0; h < NUM_HWY; h++)
        for (int a = 0; a < RX_SLOTS; a++) memM[b][h][a] = 8'h00;

    repeat (5) @(negedge clk);
    rst = 0;

    // R1: released before any frame sync
    begin
      bit seen = 0;
      repeat (12) begin @(negedge clk); if (txOe || txBit) seen = 1; end
      checks++;
      if (seen) begin
        fails++;
        $display("FAIL R1 pre-sync: actual line driven expected txOe=0");
      end
    end

    // frame 1: idle slots read before any idle write (R1), others reset to release
    setEntry(0, 8'h60, 8'h00, "R1 R7");
    setEntry(1, 8'h80, 8'h00, "R1 R7");
    setEntry(2, 8'hA0, 8'h00, "R1 R7");
    runFrame(8'h10);
    wait (framesDone == 1);

    // frame 2 configuration
    setIdle(0, 8'h11);
    setIdle(1, 8'h22);
    setIdle(2, 8'h33);
    setIdle(3, 8'h99);                     // R7: index 3 ignored
    setEntry(0, 8'h7F, 8'hEE, "R7 R11");   // idle0, junk highway and low byte
    setEntry(1, 8'h80, 8'h00, "R7");
    setEntry(2, 8'hA0, 8'h00, "R7");
    setEntry(3, 8'h60, 8'h12, "R7 R11");
    setEntry(4, 8'h40, 8'hA5, "R2 R6");
    setEntry(5, 8'h47, 8'h3C, "R6 R11");
    setEntry(6, 8'hDF, 8'h55, "R8 R11");
    setEntry(7, 8'hE0, 8'h00, "R9");
    for (int k = 0; k < 6; k++) begin
      logic [7:0] hi = 8'h20 | 8'(rxH[k]);
      logic [7:0] lo = 8'(rxA[k]);
      string t = "R5";
      if (k == 2) begin hi = hi | 8'h04; t = "R5 R3"; end
      if (k == 3) begin lo = lo | 8'h80; t = "R5 R11"; end
      setEntry(8 + k, hi, lo, t);
      hi = 8'h00 | 8'(rxH[k]);
      lo = 8'(rxA[k]);
      t = "R4";
      if (k == 1) begin hi = hi | 8'h08; t = "R4 R3"; end
      if (k == 4) begin lo = lo | 8'h80; t = "R4 R11"; end
      setEntry(16 + k, hi, lo, t);
    end
    setEntry(14, 8'h40, 8'h0F, "R6");
    setEntry(15, 8'h40, 8'hF0, "R6");
    setEntry(22, 8'h40, 8'h81, "R6");
    setEntry(23, 8'h40, 8'h7E, "R6");
    for (int s = 24; s < 28; s++) tagM[s] = "R9";
    for (int s = 28; s < 32; s++) setEntry(s, 8'h40, 8'(8'hC0 + s), "R2 R6");
    for (int k = 0; k < 6; k++) rxOne(rxH[k], rxA[k], 8'(8'h50 + k));
    patByte = 8'hC3;
    runFrame(8'h90);
    wait (framesDone == 2);

    // frame 3: new pattern, entry 4 rewritten in the middle of slot 4 (R10)
    patByte = 8'h7E;
    tagM[4] = "R10";
    runFrame(8'hB0);
    repeat (27) @(negedge clk);
    setEntry(4, 8'h40, 8'h5A, "R10");
    wait (framesDone == 3);

    // frame 4: rewritten entry now in effect (R10)
    runFrame(8'hD0);
    wait (framesDone == 4);

    repeat (4) @(negedge clk);
    finish();
  end

endmodule